// File: doc/BRIEF.md
# ATA Task File Shadow with 48-bit Address Staging

This block holds the legacy task file registers of one ATA channel on the host side of a serial ATA controller. A host reaches it with byte-wide I/O writes and reads at one channel's command block (eight consecutive addresses) and that channel's device control address. The channel, primary or secondary, is chosen by a parameter. Each of the five parameter registers (features, sector count and the three LBA bytes) keeps the last two bytes written to it. Two back-to-back writes therefore carry the upper and lower halves that a 48-bit LBA command needs.

A bit in the device control register chooses which byte a read of a parameter register returns: the newer byte or the older one. A write to the command register takes a snapshot of the whole task file and packs it into a 20-byte host-to-device register FIS. In that FIS the older byte of each register fills the expanded field and the newer byte fills the current field. The FIS leaves on a valid/ready stream, one byte per beat by default or one dword per beat. A busy flag, visible in bit 7 of status, stays set until the final beat is accepted.

Top module: `ata_taskfile_shadow`

## Requirements
- R1: After reset every parameter register (both slots), the device register and the control register read 0, status reads 0, and `fis_valid` is low.
- R2: A write to a parameter register (offset 1 features, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high) moves the stored newer byte into the older slot and stores the written byte as newer. With control bit 7 clear, a read returns the newer byte.
- R3: With control bit 7 set, a read of a parameter register returns the older byte. After a single write since reset, that older byte is 0.
- R4: A write to the device register (offset 6) or to the control register does not shift any parameter history. The device register reads back the last byte written to it.
- R5: With the default primary selection, the command block sits at 1F0h–1F7h and control sits at 3F6h. With the secondary selection they sit at 170h–177h and 376h. A write to any other address changes nothing.
- R6: A write to offset 7 while idle sets busy. On the next cycle, a status read (offset 7 or the control address) returns bit 7 = 1.
- R7: The FIS bytes in order are: 27h; 80h; command; features newer; LBA low newer; LBA mid newer; LBA high newer; device; LBA low older; LBA mid older; LBA high older; features older; count newer; count older; 00h; control; and four 00h bytes.
- R8: The FIS leaves byte 0 first, one byte per beat with the default stream width (the lowest byte in bits 7:0 of a dword beat). `fis_last` is high only on the final beat. While `fis_ready` is low, `fis_valid` and `fis_data` hold their values.
- R9: Busy and `fis_valid` clear on the cycle after the final beat is accepted. A command write while busy is ignored, and the frame in flight carries the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | ADDR_W | Host I/O address for writes and reads |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for host_addr, combinational |
| fis_valid | output | 1 | FIS stream beat valid |
| fis_ready | input | 1 | FIS stream beat accepted |
| fis_data | output | STREAM_W | FIS stream beat |
| fis_last | output | 1 | Final beat of the FIS |
| busy | output | 1 | Command in flight |

## Verification
If the history slots are shifted wrongly, the fault shows on the read directly after the next write with control bit 7 set or clear. The same fault shows again in bytes 3–13 of the next FIS. A bad decode shows as a register changing after a write aimed elsewhere, which can be seen on the very next read. A serializer fault shows within the 20 beats of one frame: the wrong byte order, `fis_last` on the wrong beat, data moving during a stall, or busy staying high after the final beat.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   localparam int FIS_BYTES  = 20;
   localparam int FIS_BITS   = FIS_BYTES * 8;
   localparam int NUM_PARAM  = 5;
   localparam logic [7:0] FIS_TYPE_H2D = 8'h27;
   localparam logic [7:0] FIS_CMD_FLAG = 8'h80;

   typedef enum logic [2:0] {
      OFS_DATA  = 3'd0,
      OFS_FEAT  = 3'd1,
      OFS_COUNT = 3'd2,
      OFS_LBAL  = 3'd3,
      OFS_LBAM  = 3'd4,
      OFS_LBAH  = 3'd5,
      OFS_DEV   = 3'd6,
      OFS_CMD   = 3'd7
   } tf_ofs_e;

   typedef struct packed {
      logic [7:0] older;
      logic [7:0] newer;
   } hist_t;

   // Byte k of the frame lands in bits [8k+7:8k].
   function automatic logic [FIS_BITS-1:0] build_fis(
      input logic [7:0] cmd,
      input hist_t      feat,
      input hist_t      cnt,
      input hist_t      lbal,
      input hist_t      lbam,
      input hist_t      lbah,
      input logic [7:0] dev,
      input logic [7:0] ctl
   );
      logic [FIS_BITS-1:0] f;
      f = '0;
      f[  0 +: 8] = FIS_TYPE_H2D;
      f[  8 +: 8] = FIS_CMD_FLAG;
      f[ 16 +: 8] = cmd;
      f[ 24 +: 8] = feat.newer;
      f[ 32 +: 8] = lbal.newer;
      f[ 40 +: 8] = lbam.newer;
      f[ 48 +: 8] = lbah.newer;
      f[ 56 +: 8] = dev;
      f[ 64 +: 8] = lbal.older;
      f[ 72 +: 8] = lbam.older;
      f[ 80 +: 8] = lbah.older;
      f[ 88 +: 8] = feat.older;
      f[ 96 +: 8] = cnt.newer;
      f[104 +: 8] = cnt.older;
      f[120 +: 8] = ctl;
      return f;
   endfunction

endpackage

// File: rtl/ata_tf_hist.sv
module ata_tf_hist
   import ata_tf_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              sel_old,
   output logic [BYTE_W-1:0] newer,
   output logic [BYTE_W-1:0] older,
   output logic [BYTE_W-1:0] rd
);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("ata_tf_hist: BYTE_W must be 8");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         newer <= '0;
         older <= '0;
      end else if (wr) begin
         older <= newer;
         newer <= wdata;
      end
   end

   assign rd = sel_old ? older : newer;

   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (older == $past(newer)) && (newer == $past(wdata))); // R2

   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(newer) && $stable(older)); // R4

endmodule

// File: rtl/ata_tf_fis_tx.sv
module ata_tf_fis_tx
   import ata_tf_pkg::*;
#(
   parameter int STREAM_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [FIS_BITS-1:0] fis_in,
   input  logic                ready,
   output logic                valid,
   output logic [STREAM_W-1:0] data,
   output logic                last
);

   localparam int BEAT_BYTES = STREAM_W / 8;
   localparam int BEATS      = FIS_BYTES / BEAT_BYTES;
   localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

   generate
      if (STREAM_W != 8 && STREAM_W != 32) begin : g_bad_stream
         $error("ata_tf_fis_tx: STREAM_W must be 8 or 32");
      end
      if ((FIS_BYTES % BEAT_BYTES) != 0) begin : g_bad_split
         $error("ata_tf_fis_tx: frame must split into whole beats");
      end
   endgenerate

   logic [FIS_BITS-1:0] fis_q;
   logic [IDX_W-1:0]    idx;
   logic [STREAM_W-1:0] beat_w [BEATS];

   genvar b;
   generate
      for (b = 0; b < BEATS; b++) begin : g_beat
         assign beat_w[b] = fis_q[b*STREAM_W +: STREAM_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fis_q <= '0;
         idx   <= '0;
         valid <= 1'b0;
      end else if (!valid) begin
         if (load) begin
            fis_q <= fis_in;
            idx   <= '0;
            valid <= 1'b1;
         end
      end else if (ready) begin
         if (idx == LAST_IDX) begin
            valid <= 1'b0;
            idx   <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign data = beat_w[idx];
   assign last = valid && (idx == LAST_IDX);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(data) && $stable(last)); // R8

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && last |=> !valid); // R9

endmodule

// File: rtl/ata_taskfile_shadow.sv
module ata_taskfile_shadow
   import ata_tf_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter bit USE_SECONDARY = 1'b0,
   parameter int STREAM_W      = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [7:0]          host_wdata,
   output logic [7:0]          host_rdata,
   output logic                fis_valid,
   input  logic                fis_ready,
   output logic [STREAM_W-1:0] fis_data,
   output logic                fis_last,
   output logic                busy
);

   localparam int BUSY_BIT = 7;
   localparam int HOB_BIT  = 7;

   logic [ADDR_W-1:0] blk_base;
   logic [ADDR_W-1:0] ctl_addr;

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ata_taskfile_shadow: ADDR_W must be at least 10");
      end
      if (USE_SECONDARY) begin : g_sec
         assign blk_base = ADDR_W'(10'h170);
         assign ctl_addr = ADDR_W'(10'h376);
      end else begin : g_pri
         assign blk_base = ADDR_W'(10'h1F0);
         assign ctl_addr = ADDR_W'(10'h3F6);
      end
   endgenerate

   logic    in_blk, is_ctl;
   tf_ofs_e ofs;

   assign in_blk = (host_addr[ADDR_W-1:3] == blk_base[ADDR_W-1:3]);
   assign is_ctl = (host_addr == ctl_addr);
   assign ofs    = tf_ofs_e'(host_addr[2:0]);

   logic [7:0] dev_q, ctl_q;
   logic       cmd_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_q <= '0;
         ctl_q <= '0;
      end else if (host_wr) begin
         if (in_blk && ofs == OFS_DEV) dev_q <= host_wdata;
         if (is_ctl)                   ctl_q <= host_wdata;
      end
   end

   hist_t      prm   [NUM_PARAM];
   logic [7:0] prm_rd[NUM_PARAM];

   genvar i;
   generate
      for (i = 0; i < NUM_PARAM; i++) begin : g_prm
         logic wr_i;
         assign wr_i = host_wr && in_blk && (host_addr[2:0] == 3'(i + 1));
         ata_tf_hist #(.BYTE_W(8)) u_hist (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_i),
            .wdata   (host_wdata),
            .sel_old (ctl_q[HOB_BIT]),
            .newer   (prm[i].newer),
            .older   (prm[i].older),
            .rd      (prm_rd[i])
         );
      end
   endgenerate

   assign cmd_fire = host_wr && in_blk && (ofs == OFS_CMD) && !busy;

   logic [FIS_BITS-1:0] fis_img;
   assign fis_img = build_fis(host_wdata, prm[0], prm[1], prm[2], prm[3],
                              prm[4], dev_q, ctl_q);

   ata_tf_fis_tx #(.STREAM_W(STREAM_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cmd_fire),
      .fis_in (fis_img),
      .ready  (fis_ready),
      .valid  (fis_valid),
      .data   (fis_data),
      .last   (fis_last)
   );

   assign busy = fis_valid;

   logic [7:0] status;
   always_comb begin
      status           = '0;
      status[BUSY_BIT] = busy;
   end

   always_comb begin
      host_rdata = '0;
      if (is_ctl) begin
         host_rdata = status;
      end else if (in_blk) begin
         unique case (ofs)
            OFS_FEAT:  host_rdata = prm_rd[0];
            OFS_COUNT: host_rdata = prm_rd[1];
            OFS_LBAL:  host_rdata = prm_rd[2];
            OFS_LBAM:  host_rdata = prm_rd[3];
            OFS_LBAH:  host_rdata = prm_rd[4];
            OFS_DEV:   host_rdata = dev_q;
            OFS_CMD:   host_rdata = status;
            default:   host_rdata = '0;
         endcase
      end
   end

   AST_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire |=> busy && fis_valid); // R6

   AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && fis_valid && !fis_ready && host_wr && in_blk && ofs == OFS_CMD
      |=> $stable(fis_data)); // R9

endmodule

// File: tb/tb_ata_taskfile_shadow.sv
module tb_ata_taskfile_shadow;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 21;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [9:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       fis_valid, fis_last, busy;
   logic       fis_ready = 1'b0;
   logic [7:0] fis_data;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // bench model of the task file
   logic [7:0] m_new[5], m_old[5], m_dev, m_ctl;

   always #(CLK_PERIOD/2) clk = ~clk;

   ata_taskfile_shadow dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .fis_valid(fis_valid), .fis_ready(fis_ready), .fis_data(fis_data),
      .fis_last(fis_last), .busy(busy)
   );

   // {write?, addr, data, expected read, requirement number}
   localparam logic [30:0] VEC [NVEC] = '{
      {1'b1, 10'h1F1, 8'h11, 8'h00, 4'd2},
      {1'b0, 10'h1F1, 8'h00, 8'h11, 4'd2},  // R2 newer
      {1'b1, 10'h1F1, 8'h22, 8'h00, 4'd2},
      {1'b0, 10'h1F1, 8'h00, 8'h22, 4'd2},  // R2 newer after shift
      {1'b1, 10'h3F6, 8'h80, 8'h00, 4'd3},
      {1'b0, 10'h1F1, 8'h00, 8'h11, 4'd3},  // R3 older
      {1'b0, 10'h1F2, 8'h00, 8'h00, 4'd3},  // R3 untouched older is 0
      {1'b1, 10'h1F6, 8'hE0, 8'h00, 4'd4},
      {1'b0, 10'h1F1, 8'h00, 8'h11, 4'd4},  // R4 device write no shift
      {1'b1, 10'h3F6, 8'h00, 8'h00, 4'd4},
      {1'b0, 10'h1F1, 8'h00, 8'h22, 4'd4},  // R4 control write no shift
      {1'b1, 10'h171, 8'h5A, 8'h00, 4'd5},
      {1'b0, 10'h1F1, 8'h00, 8'h22, 4'd5},  // R5 other channel ignored
      {1'b0, 10'h1F6, 8'h00, 8'hE0, 4'd4},  // R4 device readback
      {1'b1, 10'h1F2, 8'h05, 8'h00, 4'd2},
      {1'b1, 10'h1F2, 8'h06, 8'h00, 4'd2},
      {1'b0, 10'h1F2, 8'h00, 8'h06, 4'd2},
      {1'b1, 10'h3F6, 8'h80, 8'h00, 4'd3},
      {1'b0, 10'h1F2, 8'h00, 8'h05, 4'd3},
      {1'b1, 10'h3F6, 8'h02, 8'h00, 4'd4},
      {1'b0, 10'h1F7, 8'h00, 8'h00, 4'd6}   // R6 idle status
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic model_wr(input logic [9:0] a, input logic [7:0] d);
      if (a[9:3] == 7'h3E) begin
         if (a[2:0] >= 3'd1 && a[2:0] <= 3'd5) begin
            m_old[a[2:0]-1] = m_new[a[2:0]-1];
            m_new[a[2:0]-1] = d;
         end else if (a[2:0] == 3'd6) begin
            m_dev = d;
         end
      end else if (a == 10'h3F6) begin
         m_ctl = d;
      end
   endtask

   task automatic tf_wr(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      model_wr(a, d);
   endtask

   task automatic tf_rd(input logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   function automatic logic [7:0] exp_byte(input int k, input logic [7:0] cmd);
      case (k)
         0: return 8'h27;        1: return 8'h80;       2: return cmd;
         3: return m_new[0];     4: return m_new[2];    5: return m_new[3];
         6: return m_new[4];     7: return m_dev;       8: return m_old[2];
         9: return m_old[3];    10: return m_old[4];   11: return m_old[0];
        12: return m_new[1];    13: return m_old[1];   15: return m_ctl;
         default: return 8'h00;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] held;
      bit         stalled;
      int         n;
      for (int k = 0; k < 5; k++) begin m_new[k] = '0; m_old[k] = '0; end
      m_dev = '0; m_ctl = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 1; a <= 7; a++) begin
         tf_rd(10'h1F0 + 10'(a), rd);
         check("R1 reset readback", rd, 8'h00);
      end
      tf_rd(10'h3F6, rd);
      check("R1 reset status at control", rd, 8'h00);
      check("R1 reset fis_valid", {7'd0, fis_valid}, 8'h00);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][30]) begin
            tf_wr(VEC[v][29:20], VEC[v][19:12]);
         end else begin
            tf_rd(VEC[v][29:20], rd);
            nchk++;
            if (rd !== VEC[v][11:4]) begin
               nerr++;
               $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                        VEC[v][3:0], v, rd, VEC[v][11:4]);
            end
         end
      end

      // 48-bit LBA staging: low/mid/high each written twice
      tf_wr(10'h1F3, 8'h01); tf_wr(10'h1F3, 8'h02);
      tf_wr(10'h1F4, 8'h03); tf_wr(10'h1F4, 8'h04);
      tf_wr(10'h1F5, 8'h05); tf_wr(10'h1F5, 8'h06);

      // R6 command write sets busy
      fis_ready = 1'b0;
      tf_wr(10'h1F7, 8'h24);
      tf_rd(10'h1F7, rd);
      check("R6 status busy bit", rd, 8'h80);
      tf_rd(10'h3F6, rd);
      check("R6 control status busy bit", rd, 8'h80);
      // R9 second command while busy must be ignored (no model update needed)
      tf_wr(10'h1F7, 8'hFF);

      // R7/R8 drain with stalls
      n = 0; stalled = 1'b0; held = '0;
      for (int c = 0; c < 200 && n < 20; c++) begin
         @(negedge clk);
         fis_ready = (c % 3) != 2;
         #1;
         if (stalled) check("R8 data held during stall", fis_data, held);
         stalled = 1'b0;
         if (!fis_valid) begin
            check("R8 valid during frame", {7'd0, fis_valid}, 8'h01);
         end else if (fis_ready) begin
            check($sformatf("R7 byte %0d", n), fis_data, exp_byte(n, 8'h24));
            check($sformatf("R8 last flag beat %0d", n), {7'd0, fis_last},
                  {7'd0, (n == 19)});
            n++;
         end else begin
            stalled = 1'b1;
            held    = fis_data;
         end
      end
      check("R8 beats delivered", 8'(n), 8'd20);

      @(negedge clk);
      fis_ready = 1'b0;
      #1;
      check("R9 valid clears after last", {7'd0, fis_valid}, 8'h00);
      tf_rd(10'h1F7, rd);
      check("R9 status idle after frame", rd, 8'h00);
      repeat (3) @(negedge clk);
      #1;
      check("R9 ignored command sent nothing", {7'd0, fis_valid}, 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule